// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer (host side)

This block sits on the host side of a four-wire serial link to a 12-bit successive-approximation converter. One accepted start request runs one complete conversion. The block drops the select line, clocks out a command byte that requests external-clock conversion of the chosen input, then clocks two all-zero bytes. During those two bytes the converter returns its result. The select line is then raised.

The returned 12-bit code sits inside the two trailing received bytes, with one leading pad bit and three trailing pad bits. The block extracts the code and widens it to 16 bits. The code is zero-extended for unipolar conversions and sign-extended for bipolar (two's-complement) conversions. A single-cycle done pulse marks the result.

The serial clock half period is given in system clock cycles, so the SCLK rate can be set from about 100 kHz to 2 MHz. A deadline counter measures the conversion interval in system cycles. It raises a timeout flag when that interval reaches the configured limit, which is 120 µs by default at a 100 MHz system clock.

Top module: `conv_sequencer`

## Requirements
- R1: After synchronous reset, `cs_n_o` is 1, `sclk_o` is 0, and `busy_o`, `done_o` and `timeout_o` are 0.
- R2: The first byte sent on `mosi_o`, MSB first, has the following bits:
  - bit7 = 1
  - bits6:4 = `chan_i`
  - bit3 = `unipolar_i`
  - bit2 = `single_i`
  - bits1:0 = 11
  
  The next 16 bits sent are all 0.
- R3: SCLK idles low. `mosi_o` changes only while SCLK is low, and `miso_i` is sampled as SCLK rises. Each frame has exactly 24 rising edges, all while `cs_n_o` is 0.
- R4: Each SCLK high phase and each low phase lasts N system cycles. N is `half_div_i` latched at the accepted start, and a value of 0 is treated as 1.
- R5: `cs_n_o` falls N cycles before the first SCLK rise, and rises N cycles after the last SCLK fall.
- R6: The eight bits received during the command byte do not affect the result.
- R7: The 12-bit code is made of the bits sampled at rising edges 10 through 21, MSB first. These are bits 6:0 of the second received byte followed by bits 7:3 of the third. The pad bits at edges 9 and 22–24 are ignored.
- R8: `result_o` is the code zero-extended to 16 bits when the frame was unipolar, and sign-extended from bit 11 when it was bipolar.
- R9: `done_o` is high for exactly one cycle, in the cycle `cs_n_o` rises, with `result_o` valid. `busy_o` is high from the cycle after an accepted start until the end of the select-high recovery.
- R10: A `start_i` seen while `busy_o` is 1 is ignored. It neither changes the frame in flight nor causes a later frame.
- R11: Between two frames, `cs_n_o` stays high for at least 2N system cycles.
- R12: The conversion interval runs from the SCLK fall that ends the command byte to the 21st SCLK rise. If it lasts TIMEOUT_CYC system cycles or more, `timeout_o` is 1 when `done_o` pulses. `timeout_o` then holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion |
| chan_i | input | 3 | Channel select code placed in the command byte |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| unipolar_i | input | 1 | 1 = unipolar (straight binary), 0 = bipolar (two's complement) |
| half_div_i | input | DIV_W | SCLK half period in system cycles |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Conversion or recovery in progress |
| done_o | output | 1 | One-cycle pulse with valid result |
| result_o | output | 16 | Extended conversion result |
| timeout_o | output | 1 | Conversion interval reached the limit |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a frame. The block must ignore it, and must also leave no pending request that would launch a second frame after recovery. The stimulus pulses `start_i` with a different channel while SCLK is toggling. It then confirms that the command byte seen on the wire still carries the original channel, and that the select line stays high long after the recovery window ends. The deadline is exercised by choosing half periods just below and just above the value at which the 25N-cycle conversion interval crosses a reduced limit.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CODE_BITS  = 12;
    localparam int WIDE_BITS  = 16;
    // position of the code inside the 24-bit receive register
    localparam int CODE_LSB   = 3;
    // fall index (0-based) that closes the command byte
    localparam int CMD_LAST_FALL = 7;
    // rise index (0-based) that captures the code LSB
    localparam int CODE_LAST_RISE = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single;
    } conv_cfg_t;

    function automatic logic [7:0] cmd_byte(input conv_cfg_t cfg);
        return {1'b1, cfg.chan, cfg.unipolar, cfg.single, 2'b11};
    endfunction

    function automatic logic [WIDE_BITS-1:0] widen_code(
        input logic [CODE_BITS-1:0] code,
        input logic                 unipolar
    );
        logic fill;
        fill = unipolar ? 1'b0 : code[CODE_BITS-1];
        return {{(WIDE_BITS-CODE_BITS){fill}}, code};
    endfunction

endpackage

// File: rtl/conv_half_timer.sv
module conv_half_timer #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    assign tick_o = run && (cnt == half_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick_o) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    // R4
    half_range_chk: assert property (@(posedge clk) disable iff (rst)
        (run && half_i != '0) |-> (cnt < half_i));

endmodule

// File: rtl/conv_shifter.sv
module conv_shifter #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] load_val,
    input  logic         advance,
    input  logic         capture,
    input  logic         miso_i,
    output logic         mosi_o,
    output logic [N-1:0] rx_o
);
    logic [N-1:0] tx;

    assign mosi_o = tx[N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx   <= '0;
            rx_o <= '0;
        end else begin
            if (load)         tx <= load_val;
            else if (advance) tx <= {tx[N-2:0], 1'b0};
            if (capture)      rx_o <= {rx_o[N-2:0], miso_i};
        end
    end

endmodule

// File: rtl/conv_deadline.sv
module conv_deadline #(
    parameter int LIMIT = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic open_i,
    input  logic close_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic          active;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active    <= 1'b0;
            cnt       <= '0;
            expired_o <= 1'b0;
        end else begin
            if (open_i)       active <= 1'b1;
            else if (close_i) active <= 1'b0;
            if (active && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
            if (active && cnt == CW'(LIMIT - 1)) expired_o <= 1'b1;
        end
    end

    // R12
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !open_i && !clear) |=> $stable(cnt));

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !clear) |=> expired_o);

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int DIV_W       = 10,
    parameter int TIMEOUT_CYC = 12000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [2:0]       chan_i,
    input  logic             single_i,
    input  logic             unipolar_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic             miso_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [15:0]      result_o,
    output logic             timeout_o
);
    localparam int BW = $clog2(FRAME_BITS);

    seq_state_e       state;
    conv_cfg_t        cfg_q;
    logic [DIV_W-1:0] half_q;
    logic [BW-1:0]    bit_cnt;
    logic             gap_second;
    logic             tick;
    logic             accept;
    logic             rise_ev;
    logic             fall_ev;
    logic [FRAME_BITS-1:0] rx;
    conv_cfg_t        cfg_in;

    assign cfg_in  = '{chan: chan_i, unipolar: unipolar_i, single: single_i};
    assign accept  = (state == ST_IDLE) && start_i;
    assign rise_ev = (state == ST_LOW)  && tick;
    assign fall_ev = (state == ST_HIGH) && tick;
    assign busy_o  = (state != ST_IDLE);

    conv_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state != ST_IDLE),
        .half_i (half_q),
        .tick_o (tick)
    );

    conv_shifter #(.N(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val ({cmd_byte(cfg_in), {(FRAME_BITS-8){1'b0}}}),
        .advance  (fall_ev),
        .capture  (rise_ev),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .rx_o     (rx)
    );

    conv_deadline #(.LIMIT(TIMEOUT_CYC)) u_deadline (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .open_i    (fall_ev && bit_cnt == BW'(CMD_LAST_FALL)),
        .close_i   (rise_ev && bit_cnt == BW'(CODE_LAST_RISE)),
        .expired_o (timeout_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg_q      <= '0;
            half_q     <= DIV_W'(1);
            bit_cnt    <= '0;
            gap_second <= 1'b0;
            cs_n_o     <= 1'b1;
            sclk_o     <= 1'b0;
            done_o     <= 1'b0;
            result_o   <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_i) begin
                    cfg_q   <= cfg_in;
                    half_q  <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
                    bit_cnt <= '0;
                    cs_n_o  <= 1'b0;
                    state   <= ST_LOW;
                end
                ST_LOW: if (tick) begin
                    sclk_o <= 1'b1;
                    state  <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    sclk_o <= 1'b0;
                    if (bit_cnt == BW'(FRAME_BITS - 1)) state <= ST_HOLD;
                    else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= ST_LOW;
                    end
                end
                ST_HOLD: if (tick) begin
                    cs_n_o     <= 1'b1;
                    done_o     <= 1'b1;
                    result_o   <= widen_code(rx[CODE_LSB +: CODE_BITS], cfg_q.unipolar);
                    gap_second <= 1'b0;
                    state      <= ST_GAP;
                end
                ST_GAP: if (tick) begin
                    if (gap_second) state <= ST_IDLE;
                    gap_second <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_with_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($rose(cs_n_o) && busy_o));

    // R10
    busy_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(cfg_q));

endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic       single_i = 1'b0;
    logic       unipolar_i = 1'b0;
    logic [9:0] half_div_i = 10'd2;
    logic       miso_i;
    logic       cs_n_o, sclk_o, mosi_o, busy_o, done_o, timeout_o;
    logic [15:0] result_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_sequencer #(.DIV_W(10), .TIMEOUT_CYC(LIMIT)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
        .single_i(single_i), .unipolar_i(unipolar_i), .half_div_i(half_div_i),
        .miso_i(miso_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .timeout_o(timeout_o)
    );

    // converter model
    logic [23:0] resp = '0;
    logic [23:0] mosi_cap;
    int rise_cnt, fall_cnt, cs_falls;
    int pre_cyc, hi_cyc, post_cyc, bad_rise;
    initial begin
        rise_cnt = 0; fall_cnt = 0; cs_falls = 0;
        pre_cyc = 0; hi_cyc = 0; post_cyc = 0; bad_rise = 0;
        mosi_cap = '0;
    end

    assign miso_i = (fall_cnt < 24) ? resp[23 - fall_cnt] : 1'b0;

    always @(negedge cs_n_o) begin
        rise_cnt = 0; fall_cnt = 0; pre_cyc = 0; hi_cyc = 0; post_cyc = 0;
        cs_falls = cs_falls + 1;
    end
    always @(posedge sclk_o) begin
        if (cs_n_o) bad_rise = bad_rise + 1;
        mosi_cap = {mosi_cap[22:0], mosi_o};
        rise_cnt = rise_cnt + 1;
    end
    always @(negedge sclk_o) fall_cnt = fall_cnt + 1;
    always @(posedge clk) begin
        if (!cs_n_o && rise_cnt == 0) pre_cyc <= pre_cyc + 1;
        if (!cs_n_o && sclk_o)        hi_cyc  <= hi_cyc + 1;
        if (!cs_n_o && rise_cnt == 24 && !sclk_o) post_cyc <= post_cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1; break; end
        end
        if (!ok) chk("watchdog", 0, 1);
    endtask

    task automatic kick(input logic [2:0] ch, input logic sg, input logic un,
                        input logic [9:0] h);
        @(negedge clk);
        chan_i = ch; single_i = sg; unipolar_i = un; half_div_i = h;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        // R1
        chk("R1 cs_n", cs_n_o, 1);
        chk("R1 sclk", sclk_o, 0);
        chk("R1 busy/done/timeout", {busy_o, done_o, timeout_o}, 0);
    endtask

    task automatic t_frame(input logic [2:0] ch, input logic sg, input logic un,
                           input logic [9:0] h, input logic [11:0] code,
                           input logic [7:0] junk);
        bit ok;
        int n;
        logic [15:0] exp_res;
        n = (h == 0) ? 1 : int'(h);
        resp = {junk, 1'b1, code, 3'b111};
        exp_res = un ? {4'h0, code} : {{4{code[11]}}, code};
        kick(ch, sg, un, h);
        chk("R9 busy after start", busy_o, 1);
        wait_done(ok);
        if (ok) begin
            // R7 R8 R6
            chk("R7/R8 result", result_o, exp_res);
            chk("R9 cs rises with done", cs_n_o, 1);
            // R2
            chk("R2 command byte", mosi_cap[23:16], {1'b1, ch, un, sg, 2'b11});
            chk("R2 zero bytes", mosi_cap[15:0], 0);
            // R3
            chk("R3 rise count", rise_cnt, 24);
            // R4
            chk("R4 high cycles", hi_cyc, 24 * n);
            // R5
            chk("R5 lead", pre_cyc, n);
            chk("R5 tail", post_cyc, n);
            @(negedge clk);
            chk("R9 done one cycle", done_o, 0);
            for (int i = 0; i < 2 * n + 2; i++) @(negedge clk);
            chk("R9 busy released", busy_o, 0);
        end
    endtask

    task automatic t_junk_ignored;
        // R6: same code, two different first bytes
        t_frame(3'd5, 1'b1, 1'b1, 10'd2, 12'h3C6, 8'h00);
        t_frame(3'd5, 1'b1, 1'b1, 10'd2, 12'h3C6, 8'hFF);
        chk("R6 junk byte ignored", result_o, 16'h03C6);
    endtask

    task automatic t_busy_ignore;
        bit ok;
        int falls0;
        resp = {8'h5A, 1'b0, 12'h123, 3'b000};
        kick(3'd1, 1'b1, 1'b1, 10'd3);
        for (int i = 0; i < 40; i++) @(negedge clk);
        chan_i = 3'd6; unipolar_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        falls0 = cs_falls;
        wait_done(ok);
        // R10
        chk("R10 frame unchanged", mosi_cap[23:16], {1'b1, 3'd1, 1'b1, 1'b1, 2'b11});
        chk("R10 result unipolar kept", result_o, 16'h0123);
        for (int i = 0; i < 60; i++) @(negedge clk);
        chk("R10 no extra frame", cs_falls - falls0, 0);
        chk("R10 cs idle", cs_n_o, 1);
    endtask

    task automatic t_gap;
        bit ok;
        int gap;
        resp = '0;
        @(negedge clk);
        chan_i = 3'd2; half_div_i = 10'd5; start_i = 1'b1;
        wait_done(ok);
        gap = 0;
        while (cs_n_o && gap < 1000) begin
            gap++;
            @(negedge clk);
        end
        start_i = 1'b0;
        // R11
        chk("R11 cs high gap", (gap >= 10) ? 1 : 0, 1);
        wait_done(ok);
        for (int i = 0; i < 20; i++) @(negedge clk);
    endtask

    task automatic t_timeout;
        bit ok;
        resp = {8'h00, 1'b0, 12'h800, 3'b000};
        // R12 interval 25*13 = 325 cycles, over the limit
        kick(3'd0, 1'b0, 1'b0, 10'd13);
        chk("R12 cleared on start", timeout_o, 0);
        wait_done(ok);
        chk("R12 slow frame flagged", timeout_o, 1);
        chk("R8 bipolar negative", result_o, 16'hF800);
        for (int i = 0; i < 40; i++) @(negedge clk);
        chk("R12 flag held", timeout_o, 1);
        // R12 interval 25*11 = 275 cycles, under the limit
        kick(3'd0, 1'b0, 1'b0, 10'd11);
        chk("R12 cleared by new start", timeout_o, 0);
        wait_done(ok);
        chk("R12 fast frame not flagged", timeout_o, 0);
        for (int i = 0; i < 30; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        chk("watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frame(3'd4, 1'b1, 1'b1, 10'd2, 12'hABC, 8'hA5);
        t_frame(3'd3, 1'b0, 1'b0, 10'd4, 12'h7FF, 8'h3C);
        t_frame(3'd7, 1'b1, 1'b0, 10'd1, 12'hFFF, 8'h00);
        t_frame(3'd2, 1'b0, 1'b1, 10'd0, 12'h001, 8'hFF);
        t_junk_ignored();
        t_busy_ignore();
        t_gap();
        t_timeout();
        chk("R3 no rise with cs high", bad_rise, 0);
        summary();
    end

endmodule